// File: doc/BRIEF.md
# Effective Address Generator with Page-Cross Penalties

This block works out the 16-bit effective address of one operand for an 8-bit processor. It fetches the operand bytes that follow the opcode, plus pointer bytes from page zero when the mode needs them, over a synchronous read port with one cycle of latency. From those bytes and the X and Y index values it produces the final address and the address of the next instruction. For indexed modes it also reports whether the bus must perform a throw-away (dummy) read, at which address, and how many cycles beyond the base instruction time the access costs.

A caller places the mode, the access kind (plain read, or write / read-modify-write), the branch-taken flag, the address of the first operand byte and both index values on the inputs, and pulses `start_i`. After the fetches are done, `done_o` pulses for one cycle with every result valid. The results then stay unchanged until the next operation completes. A start seen while an operation is in flight is dropped. Executing the instruction and writing data are left to the surrounding core.

Top module: `ea_gen`

## Requirements
- R1: After reset, done_o, mem_re_o, dummy_o are 0 and ea_o, dummy_addr_o, extra_o, pc_next_o are 0.
- R2: mode_i encoding: 0 page-zero, 1 page-zero+X, 2 page-zero+Y, 3 absolute, 4 absolute+X, 5 absolute+Y, 6 X-pre-indexed pointer, 7 Y-post-indexed pointer, 8 relative branch; codes 9 to 15 behave as code 0. Operand bytes are read at pc_i and then pc_i+1, low byte first. pc_next_o is pc_i plus the operand byte count (2 for codes 3 to 5, otherwise 1), modulo 65536. Absolute mode gives the operand word, with no dummy read and extra_o 0.
- R3: Page-zero modes give {0x00, operand (+index) mod 256}, with no dummy read and extra_o 0.
- R4: Absolute+index and Y-post-indexed reads (wr_i=0): ea_o = base+index mod 65536. If the low-byte sum carries, dummy_o=1, extra_o=1 and dummy_addr_o = ea_o XOR 0x0100. Otherwise dummy_o=0 and extra_o=0.
- R5: The same modes with wr_i=1 always set dummy_o=1, with dummy_addr_o = {base high byte, low byte of the indexed sum}, and extra_o=0.
- R6: X-pre-indexed: the pointer low byte is read at (operand+X) mod 256 and the high byte at (operand+X+1) mod 256. ea_o is the pointer, with no dummy read and extra_o 0.
- R7: Y-post-indexed: the pointer is read at operand and (operand+1) mod 256, then Y is added under the R4/R5 penalty rules.
- R8: Relative: with the next address n = pc_i+1 and a signed 8-bit offset, a taken branch gives ea_o = n+offset, with extra_o=1 if the high byte is unchanged and extra_o=2 if it differs. A branch not taken gives ea_o = n and extra_o=0.
- R9: done_o is a one-cycle pulse. The outputs hold their values until the next done_o, and start_i is ignored while an operation is in progress.
- R10: Pointer fetches never leave page zero, including when the pointer address is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| mode_i | input | 4 | Addressing mode code (R2) |
| wr_i | input | 1 | 1 = write or read-modify-write, 0 = read |
| taken_i | input | 1 | Branch condition met (relative mode) |
| pc_i | input | 16 | Address of first operand byte |
| x_i | input | 8 | X index |
| y_i | input | 8 | Y index |
| mem_re_o | output | 1 | Read request |
| mem_addr_o | output | 16 | Read address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |
| done_o | output | 1 | Results valid pulse |
| ea_o | output | 16 | Effective address |
| dummy_o | output | 1 | Dummy read required |
| dummy_addr_o | output | 16 | Dummy read address |
| extra_o | output | 2 | Extra cycles beyond base count |
| pc_next_o | output | 16 | Address after the operand bytes |

## Verification
The sweeps put index values of 0x00, 0x01, 0x7F, 0x80 and 0xFF against operand bytes fetched from addresses near 0x00FE, 0xFFFE and 0xFFFF. Each run therefore lands on both sides of a low-byte carry and on 16-bit address wrap. If the design took the dummy-read high byte from the indexed sum, or charged writes a cycle, the dummy address or extra count would be wrong for half the indexed cases. Directed runs place the pointer address at 0xFF. A design that let the pointer increment carry would fetch its high byte from 0x0100 and return the wrong address. Backward branches that cross a page check that the offset is sign-extended, and an overlapping start checks that the first result survives.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;
  localparam int unsigned MW = 4;
  localparam int unsigned XW = 2;
  localparam int unsigned ZH = AW - DW;

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] byte_t;

  typedef enum logic [MW-1:0] {
    M_ZP  = 4'd0,
    M_ZPX = 4'd1,
    M_ZPY = 4'd2,
    M_ABS = 4'd3,
    M_ABX = 4'd4,
    M_ABY = 4'd5,
    M_IZX = 4'd6,
    M_IZY = 4'd7,
    M_REL = 4'd8
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_CAPT,
    S_FIN
  } seq_st_e;
endpackage

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [MW-1:0] mode_i,
  input  logic          wr_i,
  input  logic          taken_i,
  input  addr_t         pc_i,
  input  byte_t         x_i,
  input  byte_t         y_i,
  input  byte_t         rdata_i,
  output logic          mem_re_o,
  output addr_t         mem_addr_o,
  output logic          calc_o,
  output mode_e         mode_o,
  output logic          wr_o,
  output logic          taken_o,
  output addr_t         pc_o,
  output byte_t         x_o,
  output byte_t         y_o,
  output byte_t         op0_o,
  output byte_t         op1_o,
  output byte_t         pt0_o,
  output byte_t         pt1_o
);
  seq_st_e    st_q;
  logic [1:0] ridx_q;
  mode_e      mode_q;
  logic       wr_q, taken_q;
  addr_t      pc_q;
  byte_t      x_q, y_q, op0_q, op1_q, pt0_q, pt1_q;
  byte_t      zpp;
  logic       two_op, via_ptr;

  assign two_op  = (mode_q == M_ABS) || (mode_q == M_ABX) || (mode_q == M_ABY);
  assign via_ptr = (mode_q == M_IZX) || (mode_q == M_IZY);
  assign zpp     = (mode_q == M_IZX) ? byte_t'(op0_q + x_q) : op0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      ridx_q  <= '0;
      mode_q  <= M_ZP;
      wr_q    <= 1'b0;
      taken_q <= 1'b0;
      pc_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
      op0_q   <= '0;
      op1_q   <= '0;
      pt0_q   <= '0;
      pt1_q   <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          mode_q  <= (mode_i > MW'(M_REL)) ? M_ZP : mode_e'(mode_i);
          wr_q    <= wr_i;
          taken_q <= taken_i;
          pc_q    <= pc_i;
          x_q     <= x_i;
          y_q     <= y_i;
          ridx_q  <= 2'd0;
          st_q    <= S_ISSUE;
        end
        S_ISSUE: st_q <= S_CAPT;
        S_CAPT: begin
          unique case (ridx_q)
            2'd0: begin
              op0_q <= rdata_i;
              if (two_op) begin
                ridx_q <= 2'd1; st_q <= S_ISSUE;
              end else if (via_ptr) begin
                ridx_q <= 2'd2; st_q <= S_ISSUE;
              end else begin
                st_q <= S_FIN;
              end
            end
            2'd1: begin op1_q <= rdata_i; st_q <= S_FIN; end
            2'd2: begin pt0_q <= rdata_i; ridx_q <= 2'd3; st_q <= S_ISSUE; end
            default: begin pt1_q <= rdata_i; st_q <= S_FIN; end
          endcase
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (ridx_q)
      2'd0:    mem_addr_o = pc_q;
      2'd1:    mem_addr_o = pc_q + addr_t'(1);
      2'd2:    mem_addr_o = {{ZH{1'b0}}, zpp};
      default: mem_addr_o = {{ZH{1'b0}}, byte_t'(zpp + byte_t'(1))};
    endcase
  end

  assign mem_re_o = (st_q == S_ISSUE);
  assign calc_o   = (st_q == S_FIN);
  assign mode_o   = mode_q;
  assign wr_o     = wr_q;
  assign taken_o  = taken_q;
  assign pc_o     = pc_q;
  assign x_o      = x_q;
  assign y_o      = y_q;
  assign op0_o    = op0_q;
  assign op1_o    = op1_q;
  assign pt0_o    = pt0_q;
  assign pt1_o    = pt1_q;

  // R10: pointer byte fetches stay in page zero
  a_r10_ptr_in_zp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o && ridx_q[1] |-> mem_addr_o[AW-1:DW] == '0);

  // R2: an operand-high fetch only follows an operand-low capture
  a_r2_lo_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o && (ridx_q == 2'd1) |-> $past(st_q) == S_CAPT && $past(ridx_q) == 2'd0);
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
(
  input  mode_e          mode_i,
  input  logic           wr_i,
  input  logic           taken_i,
  input  addr_t          pc_i,
  input  byte_t          x_i,
  input  byte_t          y_i,
  input  byte_t          op0_i,
  input  byte_t          op1_i,
  input  byte_t          pt0_i,
  input  byte_t          pt1_i,
  output addr_t          ea_o,
  output logic           dummy_o,
  output addr_t          dummy_addr_o,
  output logic [XW-1:0]  extra_o,
  output addr_t          pc_next_o
);
  byte_t       idx;
  addr_t       base, isum, nxt, tgt;
  logic [DW:0] lo_sum;
  logic        indexed;

  always_comb begin
    idx     = (mode_i == M_ABX) ? x_i : y_i;
    base    = (mode_i == M_IZY) ? {pt1_i, pt0_i} : {op1_i, op0_i};
    lo_sum  = {1'b0, base[DW-1:0]} + {1'b0, idx};
    isum    = base + {{ZH{1'b0}}, idx};
    nxt     = pc_i + addr_t'(1);
    tgt     = nxt + {{ZH{op0_i[DW-1]}}, op0_i};
    indexed = (mode_i == M_ABX) || (mode_i == M_ABY) || (mode_i == M_IZY);

    ea_o         = {{ZH{1'b0}}, op0_i};
    dummy_o      = 1'b0;
    dummy_addr_o = '0;
    extra_o      = '0;
    pc_next_o    = nxt;

    unique case (mode_i)
      M_ZPX: ea_o = {{ZH{1'b0}}, byte_t'(op0_i + x_i)};
      M_ZPY: ea_o = {{ZH{1'b0}}, byte_t'(op0_i + y_i)};
      M_ABS: begin ea_o = {op1_i, op0_i}; pc_next_o = pc_i + addr_t'(2); end
      M_ABX, M_ABY: begin ea_o = isum; pc_next_o = pc_i + addr_t'(2); end
      M_IZX: ea_o = {pt1_i, pt0_i};
      M_IZY: ea_o = isum;
      M_REL: begin
        ea_o    = taken_i ? tgt : nxt;
        extra_o = !taken_i ? XW'(0) :
                  (nxt[AW-1:DW] != tgt[AW-1:DW]) ? XW'(2) : XW'(1);
      end
      default: ;
    endcase

    // writes/RMW always touch the unfixed address; reads only on carry
    if (indexed) begin
      if (wr_i) begin
        dummy_o      = 1'b1;
        dummy_addr_o = {base[AW-1:DW], lo_sum[DW-1:0]};
      end else if (lo_sum[DW]) begin
        dummy_o      = 1'b1;
        extra_o      = XW'(1);
        dummy_addr_o = isum ^ (addr_t'(1) << DW);
      end
    end
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [MW-1:0] mode_i,
  input  logic          wr_i,
  input  logic          taken_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [AW-1:0] ea_o,
  output logic          dummy_o,
  output logic [AW-1:0] dummy_addr_o,
  output logic [XW-1:0] extra_o,
  output logic [AW-1:0] pc_next_o
);
  logic          calc;
  mode_e         mode_l;
  logic          wr_l, taken_l;
  addr_t         pc_l;
  byte_t         x_l, y_l, op0, op1, pt0, pt1;
  addr_t         c_ea, c_daddr, c_pcn;
  logic          c_dummy;
  logic [XW-1:0] c_extra;

  ea_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .wr_i       (wr_i),
    .taken_i    (taken_i),
    .pc_i       (pc_i),
    .x_i        (x_i),
    .y_i        (y_i),
    .rdata_i    (mem_rdata_i),
    .mem_re_o   (mem_re_o),
    .mem_addr_o (mem_addr_o),
    .calc_o     (calc),
    .mode_o     (mode_l),
    .wr_o       (wr_l),
    .taken_o    (taken_l),
    .pc_o       (pc_l),
    .x_o        (x_l),
    .y_o        (y_l),
    .op0_o      (op0),
    .op1_o      (op1),
    .pt0_o      (pt0),
    .pt1_o      (pt1)
  );

  ea_calc u_calc (
    .mode_i       (mode_l),
    .wr_i         (wr_l),
    .taken_i      (taken_l),
    .pc_i         (pc_l),
    .x_i          (x_l),
    .y_i          (y_l),
    .op0_i        (op0),
    .op1_i        (op1),
    .pt0_i        (pt0),
    .pt1_i        (pt1),
    .ea_o         (c_ea),
    .dummy_o      (c_dummy),
    .dummy_addr_o (c_daddr),
    .extra_o      (c_extra),
    .pc_next_o    (c_pcn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      ea_o         <= '0;
      dummy_o      <= 1'b0;
      dummy_addr_o <= '0;
      extra_o      <= '0;
      pc_next_o    <= '0;
    end else begin
      done_o <= calc;
      if (calc) begin
        ea_o         <= c_ea;
        dummy_o      <= c_dummy;
        dummy_addr_o <= c_daddr;
        extra_o      <= c_extra;
        pc_next_o    <= c_pcn;
      end
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(ea_o) && $stable(extra_o) && $stable(dummy_o));

  a_r4_dummy_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && dummy_o |-> dummy_addr_o[DW-1:0] == ea_o[DW-1:0]);

  a_r5_write_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && wr_l && (mode_l != M_REL) |-> extra_o == '0);

  a_r8_extra_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> extra_o != 2'd3);

  a_r3_plain_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (mode_l inside {M_ZP, M_ZPX, M_ZPY, M_ABS, M_IZX}) |-> !dummy_o && extra_o == '0);
endmodule

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic        wr = 1'b0, taken = 1'b0;
  logic [15:0] pc = '0;
  logic [7:0]  x = '0, y = '0;
  logic        mem_re;
  logic [15:0] mem_addr;
  logic [7:0]  rdata = '0;
  logic        done, dummy;
  logic [15:0] ea, daddr, pcn;
  logic [1:0]  extra;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  ea_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .wr_i(wr),
    .taken_i(taken), .pc_i(pc), .x_i(x), .y_i(y), .mem_re_o(mem_re),
    .mem_addr_o(mem_addr), .mem_rdata_i(rdata), .done_o(done), .ea_o(ea),
    .dummy_o(dummy), .dummy_addr_o(daddr), .extra_o(extra), .pc_next_o(pcn)
  );

  function automatic int memf(input int a);
    return (((a % 256) * 37) ^ ((a / 256) % 256) ^ 195) & 255;
  endfunction

  always_ff @(posedge clk) if (mem_re) rdata <= 8'(memf(int'(mem_addr)));

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input int md, input int w, input int tk, input int p,
                       input int xi, input int yi, output int e_ea, output int e_dm,
                       output int e_da, output int e_ex, output int e_pn);
    int op0, op1, base, idx, zp, nxt, off, tgt;
    op0 = memf(p); op1 = memf((p + 1) % 65536);
    e_dm = 0; e_da = 0; e_ex = 0; e_pn = (p + 1) % 65536; e_ea = op0;
    base = 0; idx = 0;
    case (md)
      1: e_ea = (op0 + xi) % 256;
      2: e_ea = (op0 + yi) % 256;
      3: begin e_ea = op1 * 256 + op0; e_pn = (p + 2) % 65536; end
      4, 5: begin
        base = op1 * 256 + op0; idx = (md == 4) ? xi : yi;
        e_ea = (base + idx) % 65536; e_pn = (p + 2) % 65536;
      end
      6: begin
        zp = (op0 + xi) % 256;
        e_ea = memf((zp + 1) % 256) * 256 + memf(zp);
      end
      7: begin
        base = memf((op0 + 1) % 256) * 256 + memf(op0); idx = yi;
        e_ea = (base + idx) % 65536;
      end
      8: begin
        nxt = (p + 1) % 65536;
        off = (op0 >= 128) ? op0 - 256 : op0;
        tgt = (nxt + off + 65536) % 65536;
        if (tk != 0) begin
          e_ea = tgt; e_ex = ((nxt / 256) != (tgt / 256)) ? 2 : 1;
        end else e_ea = nxt;
      end
      default: ;
    endcase
    if (md == 4 || md == 5 || md == 7) begin
      if (w != 0) begin
        e_dm = 1; e_da = (base / 256) * 256 + (e_ea % 256);
      end else if ((base % 256) + idx > 255) begin
        e_dm = 1; e_ex = 1; e_da = e_ea ^ 256;
      end
    end
  endtask

  function automatic string req_of(input int md, input int w);
    case (md)
      0, 1, 2: return "R3";
      3: return "R2";
      4, 5: return (w != 0) ? "R5" : "R4";
      6: return "R6";
      7: return (w != 0) ? "R7_R5" : "R7_R4";
      8: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic wait_done();
    int n = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    if (!done) begin
      fails++;
      $display("FAIL R9 done_timeout actual=0 expected=1");
    end
  endtask

  task automatic run(input int md, input int w, input int tk, input int p,
                     input int xi, input int yi, input string tag);
    int e_ea, e_dm, e_da, e_ex, e_pn;
    string r;
    model(md, w, tk, p, xi, yi, e_ea, e_dm, e_da, e_ex, e_pn);
    r = (tag == "") ? req_of(md, w) : tag;
    @(negedge clk);
    mode = 4'(md); wr = 1'(w); taken = 1'(tk); pc = 16'(p); x = 8'(xi); y = 8'(yi);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(r, "ea", int'(ea), e_ea);
    chk(r, "dummy", int'(dummy), e_dm);
    chk(r, "dummy_addr", int'(daddr), e_da);
    chk(r, "extra", int'(extra), e_ex);
    chk("R2", "pc_next", int'(pcn), e_pn);
  endtask

  initial begin
    int pcs[8] = '{16'h0000, 16'h00FE, 16'h12FF, 16'h7FF0, 16'h80FE, 16'hFFFE, 16'hFFFF, 16'h3456};
    int ixs[5] = '{0, 1, 8'h7F, 8'h80, 8'hFF};
    int e_ea, e_dm, e_da, e_ex, e_pn, held, p_ff;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "done", int'(done), 0);
    chk("R1", "mem_re", int'(mem_re), 0);
    chk("R1", "ea", int'(ea), 0);
    chk("R1", "dummy", int'(dummy), 0);
    chk("R1", "extra", int'(extra), 0);
    chk("R1", "pc_next", int'(pcn), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done_after_release", int'(done), 0);

    for (int md = 0; md < 11; md++)
      for (int w = 0; w < 2; w++)
        for (int tk = 0; tk < 2; tk++)
          for (int pi = 0; pi < 8; pi++)
            for (int ii = 0; ii < 5; ii++)
              run(md, w, tk, pcs[pi], ixs[ii], ixs[4 - ii], "");

    // R6 R10: X-pre-indexed pointer address lands on 0xFF
    for (int pi = 0; pi < 8; pi++)
      run(6, 0, 0, pcs[pi], (255 - memf(pcs[pi])) & 255, 0, "R10_R6");
    // R7 R10: operand byte 0xFF for Y-post-indexed
    p_ff = 0;
    for (int a = 0; a < 65536; a++) if (memf(a) == 255) begin p_ff = a; break; end
    run(7, 0, 0, p_ff, 0, 8'h80, "R10_R7");
    run(7, 1, 0, p_ff, 0, 8'hFF, "R10_R7");

    // R9: start during busy is ignored, pulse is one cycle, results hold
    model(4, 0, 0, 16'h1234, 8'hF0, 0, e_ea, e_dm, e_da, e_ex, e_pn);
    @(negedge clk);
    mode = 4'd4; wr = 1'b0; taken = 1'b0; pc = 16'h1234; x = 8'hF0; y = 8'h00;
    start = 1'b1;
    @(negedge clk);
    mode = 4'd0; pc = 16'h00FE; x = 8'h11;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R9", "ea_first_op_kept", int'(ea), e_ea);
    chk("R9", "extra_first_op_kept", int'(extra), e_ex);
    held = int'(ea);
    @(negedge clk);
    chk("R9", "done_width", int'(done), 0);
    repeat (5) @(negedge clk);
    chk("R9", "ea_hold", int'(ea), held);
    chk("R9", "no_spurious_done", int'(done), 0);

    finish_run();
  end
endmodule